// File: doc/BRIEF.md
# I2C master byte controller

This block is the only master on an I2C bus. It turns single commands from a local controller into bus activity: a start condition, a stop condition, one byte sent, or one byte received. A byte received ends with an acknowledge bit that the caller chooses. The controller never pulls either bus line high. SCL and SDA leave the block as drive-low enables, and an external pull-up supplies the high level. The bus level of SDA comes back in on one input.

SCL timing comes from the system clock. Each SCL period is split into four quarter phases, and each phase lasts `CLK_DIV` system cycles. SDA is moved only in a quarter where SCL is low and is sampled at the end of the first high quarter. Each byte takes nine SCL clocks: eight data bits, most significant bit first, followed by the acknowledge bit from the receiver. The caller builds a transaction from these steps: start, address byte (7-bit address followed by the R/W bit, 1 = read), data bytes, then stop. A new start issued while the bus is held produces a repeated start with no stop before it.

Top module: `i2cm_byte_ctrl`

## Requirements
- R1: During and after reset, `cmd_ready`=1, `busy`=0, `done`=0, `scl_oe`=0 and `sda_oe`=0. Both lines are released whenever the controller is ready and the bus is free.
- R2: A start command issued on a free bus gives one SDA high-to-low transition while SCL is high, after which SCL falls. `busy` is set when the command is accepted.
- R3: Outside start and stop conditions, SDA changes only while SCL is low. SCL and SDA never change in the same system cycle.
- R4: A write command (`cmd_op`=3) puts the 8 bits of `cmd_wdata` on SDA, most significant bit first, one bit per SCL high period.
- R5: On the ninth clock of a write, the controller releases SDA. `rx_nack` reports the level sampled there: 0 means ACK, 1 means NACK.
- R6: A read command (`cmd_op`=4) releases SDA for eight clocks and returns the sampled bits in `rd_data`, first bit as bit 7. On the ninth clock it drives SDA low if `cmd_nack`=0 and leaves it high if `cmd_nack`=1, and `rx_nack` shows that level. After a write, `rd_data` holds the byte seen on the bus.
- R7: A start command (`cmd_op`=1) issued while `busy`=1 releases SDA while SCL is low and then produces a start condition with no stop before it. `busy` stays 1.
- R8: A stop command (`cmd_op`=2) issued while `busy`=1 raises SDA while SCL is high. `busy` falls in the same cycle that `done` pulses, and both lines are then released.
- R9: A command is taken only in a cycle where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` is 1 only while idle. Each taken command ends with a `done` pulse exactly one cycle wide. A command held through the end of an earlier one is taken only after that earlier `done`.
- R10: While `busy`=0, a write, read or stop command (or any code other than 1 to 4) causes no activity on either line and completes with `done` on the next cycle. `rd_data` and `rx_nack` keep their values.
- R11: Every SCL high period inside a transaction lasts exactly 2×`CLK_DIV` system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Controller idle, command taken this cycle if valid |
| cmd_op | input | 3 | 1 start, 2 stop, 3 write byte, 4 read byte |
| cmd_wdata | input | 8 | Byte to send on a write |
| cmd_nack | input | 1 | On a read: 1 leaves the acknowledge bit high |
| done | output | 1 | One-cycle pulse when a command finishes |
| busy | output | 1 | Bus held from start until stop completes |
| rd_data | output | 8 | Byte sampled during the last read or write |
| rx_nack | output | 1 | Ninth-clock SDA level of the last byte |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | Level of the SDA line |

## Verification
The end of one step and the acceptance of the next can meet at the command interface. A stop held on `cmd_valid` through the final quarter of a byte must wait out the `done` cycle, and it must not cut off the acknowledge clock. The bench holds a stop request valid from the moment a write is accepted. At the `done` of that write it confirms that the slave model saw the full byte and that no stop condition has appeared yet. It then confirms that the stop arrives only afterwards, with `busy` dropping together with its own `done`. A bus monitor in the bench also flags any cycle in which both lines move at once and any SCL high period of the wrong length.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  localparam int BYTE_BITS = 8;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_START = 3'd1,
    OP_STOP  = 3'd2,
    OP_WRITE = 3'd3,
    OP_READ  = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    SEG_START = 2'd0,
    SEG_STOP  = 2'd1,
    SEG_BIT   = 2'd2
  } seg_e;

endpackage

// File: rtl/i2cm_quarter_tick.sv
module i2cm_quarter_tick #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);

  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = run && (cnt == LAST);

  generate
    if (CLK_DIV > 1) begin : g_gap
      // R11: quarter ticks are never back to back when the divider exceeds one
      a_r11_tick_gap: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/i2cm_bit_engine.sv
module i2cm_bit_engine
  import i2cm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic go,
  input  seg_e go_seg,
  input  logic go_bit,
  input  logic sda_in,
  output logic run,
  output logic seg_done,
  output logic rx_bit,
  output logic scl_rel,
  output logic sda_rel
);

  seg_e       seg;
  logic [1:0] phase;
  logic       dbit;
  logic       owned;

  // Line levels per quarter: {scl, sda}, 1 = released
  function automatic logic [1:0] levels(seg_e s, logic [1:0] p, logic d, logic own);
    logic [1:0] r;
    case (s)
      SEG_START: begin
        case (p)
          2'd0:    r = {!own, 1'b1};
          2'd1:    r = 2'b11;
          2'd2:    r = 2'b10;
          default: r = 2'b00;
        endcase
      end
      SEG_STOP: begin
        case (p)
          2'd0:    r = 2'b00;
          2'd1:    r = 2'b10;
          default: r = 2'b11;
        endcase
      end
      default: r = {(p == 2'd1) || (p == 2'd2), d};
    endcase
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      run     <= 1'b0;
      seg     <= SEG_BIT;
      phase   <= 2'd0;
      dbit    <= 1'b1;
      owned   <= 1'b0;
      rx_bit  <= 1'b1;
      scl_rel <= 1'b1;
      sda_rel <= 1'b1;
    end else if (go) begin
      run                <= 1'b1;
      seg                <= go_seg;
      phase              <= 2'd0;
      dbit               <= go_bit;
      {scl_rel, sda_rel} <= levels(go_seg, 2'd0, go_bit, owned);
    end else if (run && tick) begin
      if (phase == 2'd1 && seg == SEG_BIT) begin
        rx_bit <= sda_in;
      end
      if (phase == 2'd3) begin
        run <= 1'b0;
        if (seg == SEG_START) owned <= 1'b1;
        if (seg == SEG_STOP)  owned <= 1'b0;
      end else begin
        phase              <= phase + 2'd1;
        {scl_rel, sda_rel} <= levels(seg, phase + 2'd1, dbit, owned);
      end
    end
  end

  assign seg_done = run && tick && (phase == 2'd3);

  // R9: a new segment is only launched into an idle engine
  a_r9_go_when_idle: assert property (@(posedge clk) disable iff (rst)
    go |-> !run);

  // R3: the two lines never move in the same cycle
  a_r3_one_line_moves: assert property (@(posedge clk) disable iff (rst)
    !($changed(scl_rel) && $changed(sda_rel)));

  // R3: SDA moving under a high SCL only happens inside a start or stop
  a_r3_sda_steady_high: assert property (@(posedge clk) disable iff (rst)
    ($changed(sda_rel) && scl_rel && $past(scl_rel)) |-> (seg != SEG_BIT));

  // R8: a rising SDA under a high SCL belongs to a stop
  a_r8_stop_edge: assert property (@(posedge clk) disable iff (rst)
    ($rose(sda_rel) && scl_rel) |-> (seg == SEG_STOP));

  // R2: a falling SDA under a high SCL belongs to a start
  a_r2_start_edge: assert property (@(posedge clk) disable iff (rst)
    ($fell(sda_rel) && scl_rel) |-> (seg == SEG_START));

endmodule

// File: rtl/i2cm_byte_ctrl.sv
module i2cm_byte_ctrl
  import i2cm_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [2:0] cmd_op,
  input  logic [7:0] cmd_wdata,
  input  logic       cmd_nack,
  output logic       done,
  output logic       busy,
  output logic [7:0] rd_data,
  output logic       rx_nack,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       sda_in
);

  localparam int BCW = $clog2(BYTE_BITS + 1);
  localparam logic [BCW-1:0] ACK_SLOT  = BCW'(BYTE_BITS);
  localparam logic [BCW-1:0] LAST_DATA = BCW'(BYTE_BITS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SEG, ST_BITS, ST_FIN} state_e;

  state_e               state;
  logic                 go;
  seg_e                 go_seg;
  logic                 go_bit;
  logic [BYTE_BITS-1:0] shreg;
  logic [BCW-1:0]       bcnt;
  logic                 ack_drv;
  logic                 busy_q;
  logic [BYTE_BITS-1:0] rd_q;
  logic                 rxn_q;

  logic tick, eng_run, seg_done, rx_bit, scl_rel, sda_rel;

  i2cm_quarter_tick #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .run  (eng_run),
    .tick (tick)
  );

  i2cm_bit_engine u_eng (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .go       (go),
    .go_seg   (go_seg),
    .go_bit   (go_bit),
    .sda_in   (sda_in),
    .run      (eng_run),
    .seg_done (seg_done),
    .rx_bit   (rx_bit),
    .scl_rel  (scl_rel),
    .sda_rel  (sda_rel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      go      <= 1'b0;
      go_seg  <= SEG_BIT;
      go_bit  <= 1'b1;
      shreg   <= '0;
      bcnt    <= '0;
      ack_drv <= 1'b1;
      busy_q  <= 1'b0;
      rd_q    <= '0;
      rxn_q   <= 1'b0;
    end else begin
      go <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cmd_valid) begin
            case (op_e'(cmd_op))
              OP_START: begin
                go     <= 1'b1;
                go_seg <= SEG_START;
                go_bit <= 1'b1;
                busy_q <= 1'b1;
                state  <= ST_SEG;
              end
              OP_STOP: begin
                if (busy_q) begin
                  go     <= 1'b1;
                  go_seg <= SEG_STOP;
                  go_bit <= 1'b0;
                  state  <= ST_SEG;
                end else begin
                  state <= ST_FIN;
                end
              end
              OP_WRITE, OP_READ: begin
                if (busy_q) begin
                  shreg   <= (cmd_op == OP_WRITE) ? cmd_wdata : '1;
                  ack_drv <= (cmd_op == OP_WRITE) ? 1'b1 : cmd_nack;
                  bcnt    <= '0;
                  go      <= 1'b1;
                  go_seg  <= SEG_BIT;
                  go_bit  <= (cmd_op == OP_WRITE) ? cmd_wdata[BYTE_BITS-1] : 1'b1;
                  state   <= ST_BITS;
                end else begin
                  state <= ST_FIN;
                end
              end
              default: state <= ST_FIN;
            endcase
          end
        end
        ST_SEG: begin
          if (seg_done) begin
            if (go_seg == SEG_STOP) busy_q <= 1'b0;
            state <= ST_FIN;
          end
        end
        ST_BITS: begin
          if (seg_done) begin
            if (bcnt == ACK_SLOT) begin
              rxn_q <= rx_bit;
              rd_q  <= shreg;
              state <= ST_FIN;
            end else begin
              shreg  <= {shreg[BYTE_BITS-2:0], rx_bit};
              bcnt   <= bcnt + 1'b1;
              go     <= 1'b1;
              go_bit <= (bcnt == LAST_DATA) ? ack_drv : shreg[BYTE_BITS-2];
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready = (state == ST_IDLE);
  assign done      = (state == ST_FIN);
  assign busy      = busy_q;
  assign rd_data   = rd_q;
  assign rx_nack   = rxn_q;
  assign scl_oe    = !scl_rel;
  assign sda_oe    = !sda_rel;

  // R9: done never lasts two cycles
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: a taken command leaves the idle state
  a_r9_take_leaves_idle: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  // R8: the bus is given up only together with a completion
  a_r8_busy_drop: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R1: idle with a free bus means both lines released
  a_r1_free_released: assert property (@(posedge clk) disable iff (rst)
    (cmd_ready && !busy) |-> (!scl_oe && !sda_oe));

  // R10: non-start commands on a free bus finish at once
  a_r10_free_fast: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && !busy && cmd_op != 3'd1) |=> done);

  // R5: the controller never pulls SDA on the acknowledge clock of a write
  a_r5_ack_released: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BITS && bcnt == ACK_SLOT && ack_drv && eng_run) |-> !sda_oe);

endmodule

// File: tb/i2cm_byte_ctrl_tb.sv
module i2cm_byte_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 3;
  localparam int WD_LIMIT   = 100000;
  localparam int NVEC       = 10;

  typedef struct packed {
    logic [2:0] op;
    logic [7:0] wd;
    logic       mnack;
    logic       stx_en;
    logic [7:0] stx;
    logic       snack;
    logic [7:0] exp_rd;
    logic       exp_rxn;
    logic       exp_busy;
    logic [1:0] exp_starts;
    logic       exp_stop;
  } vec_t;

  // op, wd, mnack, slave-tx, slave byte, slave nack, rd, rx_nack, busy, starts, stop
  localparam vec_t VECS [NVEC] = '{
    '{3'd1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 2'd1, 1'b0},
    '{3'd3, 8'h9A, 1'b0, 1'b0, 8'h00, 1'b0, 8'h9A, 1'b0, 1'b1, 2'd0, 1'b0},
    '{3'd3, 8'hF0, 1'b0, 1'b0, 8'h00, 1'b1, 8'hF0, 1'b1, 1'b1, 2'd0, 1'b0},
    '{3'd1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 8'hF0, 1'b1, 1'b1, 2'd1, 1'b0},
    '{3'd3, 8'h9B, 1'b0, 1'b0, 8'h00, 1'b0, 8'h9B, 1'b0, 1'b1, 2'd0, 1'b0},
    '{3'd4, 8'h00, 1'b0, 1'b1, 8'hC5, 1'b0, 8'hC5, 1'b0, 1'b1, 2'd0, 1'b0},
    '{3'd4, 8'h00, 1'b1, 1'b1, 8'h3C, 1'b0, 8'h3C, 1'b1, 1'b1, 2'd0, 1'b0},
    '{3'd2, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 8'h3C, 1'b1, 1'b0, 2'd0, 1'b1},
    '{3'd3, 8'h55, 1'b0, 1'b0, 8'h00, 1'b0, 8'h3C, 1'b1, 1'b0, 2'd0, 1'b0},
    '{3'd4, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 8'h3C, 1'b1, 1'b0, 2'd0, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [7:0] cmd_wdata = 8'h00;
  logic       cmd_nack = 1'b0;
  logic       cmd_ready, done, busy, rx_nack, scl_oe, sda_oe, sda_in;
  logic [7:0] rd_data;

  // slave model state
  logic       spull = 1'b0;
  logic       stx_en = 1'b0;
  logic [7:0] stx = 8'h00;
  logic       snack = 1'b0;
  logic       nacked = 1'b0;
  logic [7:0] sh = 8'h00;
  logic [7:0] sbyte = 8'h00;
  logic       sack = 1'b0;
  logic       prev_scl = 1'b1;
  logic       prev_sda = 1'b1;
  logic       rose_seen = 1'b0;
  int         k = 0;
  int         hcnt = 0;
  int         starts = 0;
  int         stops = 0;
  int         bad_edges = 0;
  int         bad_high = 0;
  int         act_cnt = 0;
  int         cyc = 0;
  int         total = 0;
  int         fails = 0;

  assign sda_in = !(sda_oe || spull);

  always #(CLK_PERIOD/2) clk = !clk;

  i2cm_byte_ctrl #(.CLK_DIV(DIV)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .cmd_wdata (cmd_wdata),
    .cmd_nack  (cmd_nack),
    .done      (done),
    .busy      (busy),
    .rd_data   (rd_data),
    .rx_nack   (rx_nack),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .sda_in    (sda_in)
  );

  // Bus monitor and slave model, evaluated away from the active edge
  always @(negedge clk) begin
    logic scl_now, sda_now;
    scl_now = !scl_oe;
    sda_now = sda_in;
    if (!rst) begin
      if (scl_oe || sda_oe) act_cnt++;
      if (scl_now != prev_scl && sda_now != prev_sda) bad_edges++;
      if (scl_now && prev_scl && sda_now != prev_sda) begin
        if (!sda_now) begin
          starts++;
          k = 0;
          nacked = 1'b0;
        end else begin
          stops++;
          k = 0;
          rose_seen = 1'b0;
        end
      end
      if (scl_now && !prev_scl) begin
        rose_seen = 1'b1;
        hcnt = 1;
        if (k < 8) begin
          sh = {sh[6:0], sda_now};
        end else begin
          sbyte = sh;
          sack = sda_now;
          if (stx_en && sda_now) nacked = 1'b1;
        end
        k++;
      end else if (scl_now && prev_scl) begin
        hcnt++;
      end
      if (!scl_now && prev_scl) begin
        if (rose_seen && hcnt != 2 * DIV) bad_high++;
        if (k >= 9) k = 0;
      end
      if (!scl_now) begin
        if (stx_en && !nacked) spull = (k < 8) ? !stx[7 - k] : 1'b0;
        else                   spull = (k == 8) ? !snack : 1'b0;
      end
    end
    prev_scl = scl_now;
    prev_sda = sda_now;
  end

  // Watchdog
  always @(negedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      fails++;
      total++;
      $display("FAIL R9 watchdog: actual=%0d cycles expected<%0d", cyc, WD_LIMIT);
      $display("[TB] %0d tests run, %0d failed", total, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [7:0] wd, input logic nk);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_op    = op;
    cmd_wdata = wd;
    cmd_nack  = nk;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  initial begin
    int s0, p0, a0;
    repeat (5) @(negedge clk);
    // R1: reset state
    chk(cmd_ready == 1'b1, "R1 ready in reset", cmd_ready, 1);
    chk(busy == 1'b0 && done == 1'b0, "R1 busy/done in reset", {busy, done}, 0);
    chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R1 lines released in reset", {scl_oe, sda_oe}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(cmd_ready && !busy && !scl_oe && !sda_oe, "R1 after reset",
        {cmd_ready, busy, scl_oe, sda_oe}, 4'b1000);

    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      v = VECS[i];
      stx_en = v.stx_en;
      stx    = v.stx;
      snack  = v.snack;
      s0 = starts;
      p0 = stops;
      a0 = act_cnt;
      issue(v.op, v.wd, v.mnack);
      wait_done();
      // R9 done seen; R6 / R4 data; R5 acknowledge; R2/R7 starts; R8 stop
      chk(rd_data == v.exp_rd, "R6 rd_data", rd_data, v.exp_rd);
      chk(rx_nack == v.exp_rxn, "R5 rx_nack", rx_nack, v.exp_rxn);
      chk(busy == v.exp_busy, "R2/R8 busy", busy, v.exp_busy);
      chk(starts - s0 == int'(v.exp_starts), "R2/R7 start count", starts - s0, v.exp_starts);
      chk(stops - p0 == int'(v.exp_stop), "R8 stop count", stops - p0, v.exp_stop);
      if ((v.op == 3'd3 || v.op == 3'd4) && v.exp_busy) begin
        chk(sbyte == (v.op == 3'd3 ? v.wd : v.stx), "R4 byte on bus", sbyte,
            (v.op == 3'd3 ? v.wd : v.stx));
        chk(sack == v.exp_rxn, "R5 ninth-clock level", sack, v.exp_rxn);
      end
      if (v.op != 3'd1 && !v.exp_busy && v.op != 3'd2) begin
        chk(act_cnt == a0, "R10 no line activity on free bus", act_cnt - a0, 0);
      end
      if (v.op == 3'd2) begin
        @(negedge clk);
        chk(!scl_oe && !sda_oe, "R8 lines released after stop", {scl_oe, sda_oe}, 0);
      end
    end

    // R10: stop on a free bus
    a0 = act_cnt;
    issue(3'd2, 8'h00, 1'b0);
    wait_done();
    chk(act_cnt == a0 && !busy, "R10 stop on free bus", act_cnt - a0, 0);

    // R9: stop held valid across the end of a write
    stx_en = 1'b0;
    snack  = 1'b0;
    issue(3'd1, 8'h00, 1'b0);
    wait_done();
    p0 = stops;
    issue(3'd3, 8'h12, 1'b0);
    cmd_op    = 3'd2;
    cmd_valid = 1'b1;
    wait_done();
    chk(stops == p0, "R9 held stop not taken before done", stops - p0, 0);
    chk(sbyte == 8'h12 && sack == 1'b0, "R9 byte complete before stop", sbyte, 8'h12);
    chk(busy == 1'b1, "R9 busy held while stop waits", busy, 1);
    @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(cmd_ready == 1'b0, "R9 held stop taken after done", cmd_ready, 0);
    wait_done();
    chk(stops == p0 + 1 && busy == 1'b0, "R8 stop after held request", stops - p0, 1);

    // R3 / R11: bus monitor totals
    chk(bad_edges == 0, "R3 lines moved together", bad_edges, 0);
    chk(bad_high == 0, "R11 SCL high length", bad_high, 0);

    $display("[TB] %0d tests run, %0d failed", total, fails);
    $finish;
  end

endmodule